// File: doc/BRIEF.md
# Online Temporal Channel Shift Unit

This unit sits in a streaming activation path between two convolution stages and gives a frame-by-frame image network a view of the previous frame. Each inference round delivers one activation tensor as a stream of words. Each word carries its channel index and its spatial position. The leading eighth of the channels is exchanged with a stored copy of the same channels taken during the previous round. Every other channel passes through untouched.

The unit has two outputs. The shifted output carries the post-exchange tensor for the convolution branch. The residual output carries the unmodified input for the shortcut branch. Both outputs share one set of position and channel tags, and they keep the input order.

The store holds (C/8) x H x W words. The unit reads each location and then overwrites it with the current value in the same cycle. A one-cycle clear input empties the store, so the next frame sees zeros in the exchanged channels.

Top module: `tshift_unit`

## Requirements
- R1: After reset, `shiftValid` and `resValid` are low and `inReady` is high.
- R2: For a word with channel index below CHANNELS/8, `shiftData` equals the word accepted at the same position and channel in the previous frame.
- R3: For a word with channel index CHANNELS/8 or above, `shiftData` equals that word's input data.
- R4: `resData` equals the accepted input data for every word, whatever its channel.
- R5: In the first frame after reset, every word with channel index below CHANNELS/8 produces zero on `shiftData`.
- R6: While `clearBuf` is high, `inReady` is low. In the frame that follows a clear, the low channels produce zero on `shiftData`.
- R7: The store is read before it is written. A frame's low-channel values are what the next frame receives, and older frames are not.
- R8: `outChan` and `outPos` repeat the input tags. Both output streams keep the input order, which is channel fastest within each position.
- R9: When either output holds a word that its consumer has not taken, `inReady` is low and that output's data stays stable. Each input word appears exactly once on each output.
- R10: A word accepted at a clock edge makes both `shiftValid` and `resValid` high after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| clearBuf | input | 1 | Empties the store of previous-round channels |
| inValid | input | 1 | Input word valid |
| inReady | output | 1 | Unit can accept a word |
| inData | input | DATA_W | Activation value |
| inChan | input | CH_W | Channel index of the word |
| inPos | input | POS_W | Spatial position of the word (row * WIDTH + column) |
| shiftValid | output | 1 | Shifted output word valid |
| shiftReady | input | 1 | Shifted output consumer ready |
| shiftData | output | DATA_W | Post-exchange activation |
| resValid | output | 1 | Residual output word valid |
| resReady | input | 1 | Residual output consumer ready |
| resData | output | DATA_W | Unmodified activation |
| outChan | output | CH_W | Channel tag of the output word |
| outPos | output | POS_W | Position tag of the output word |

## Verification
The bench sends several consecutive frames. Each frame uses a different backpressure pattern: one output held back, the other held back, or both stalled in offset rhythms.

A design that wrote the store before reading it would return the current frame's own values. A design that mapped the address wrongly would return another channel's history. In both cases the expected-value comparison on the low channels flags the error.

A clear in the middle of the run checks that the low channels return to zero instead of stale data. Lopsided stalls would expose a design that dropped or repeated words. The bench counts words on each output and confirms that no extra valid appears afterwards.

// File: rtl/tshift_pkg.sv
package tshift_pkg;

  // Strobes issued by the control to the datapath each cycle
  typedef struct packed {
    logic accept;  // input word taken this cycle
    logic clear;   // empty the history store
  } tshift_strobe_t;

endpackage

// File: rtl/tshift_ctrl.sv
module tshift_ctrl
  import tshift_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           clearBuf,
  input  logic           inValid,
  output logic           inReady,
  output logic           shiftValid,
  input  logic           shiftReady,
  output logic           resValid,
  input  logic           resReady,
  output tshift_strobe_t strobe
);

  logic shiftPend;
  logic resPend;
  logic canLoad;

  // The shared output stage may reload only when both sides are free or draining
  assign canLoad = (!shiftPend || shiftReady) && (!resPend || resReady);
  assign inReady = canLoad && !clearBuf;

  assign strobe.accept = inValid && inReady;
  assign strobe.clear  = clearBuf;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftPend <= 1'b0;
      resPend   <= 1'b0;
    end else begin
      if (strobe.accept)   shiftPend <= 1'b1;
      else if (shiftReady) shiftPend <= 1'b0;
      if (strobe.accept)   resPend   <= 1'b1;
      else if (resReady)   resPend   <= 1'b0;
    end
  end

  assign shiftValid = shiftPend;
  assign resValid   = resPend;

  AST_SHIFT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    shiftValid && !shiftReady |=> shiftValid) else $error("shift word lost"); // R9
  AST_RES_HELD: assert property (@(posedge clk) disable iff (!rstN)
    resValid && !resReady |=> resValid) else $error("residual word lost"); // R9
  AST_LOAD_RAISES_VALID: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> shiftValid && resValid) else $error("latency"); // R10

endmodule

// File: rtl/tshift_dp.sv
module tshift_dp
  import tshift_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CHANNELS = 16,
  parameter int SITES    = 4,
  parameter int CH_W     = 4,
  parameter int POS_W    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  tshift_strobe_t    strobe,
  input  logic [DATA_W-1:0] inData,
  input  logic [CH_W-1:0]   inChan,
  input  logic [POS_W-1:0]  inPos,
  output logic [DATA_W-1:0] shiftData,
  output logic [DATA_W-1:0] resData,
  output logic [CH_W-1:0]   outChan,
  output logic [POS_W-1:0]  outPos
);

  localparam int SHIFT_CH = CHANNELS / 8;
  localparam int DEPTH    = SHIFT_CH * SITES;
  localparam int ADDR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] store [DEPTH];
  logic [DEPTH-1:0]  filled;
  logic [ADDR_W-1:0] addr;
  logic              isShifted;
  logic [DATA_W-1:0] oldVal;

  assign isShifted = (32'(inChan) < SHIFT_CH);
  assign addr = ADDR_W'(32'(inPos) * SHIFT_CH + 32'(inChan));

  // Location never written since reset/clear reads as zero
  always_comb begin
    oldVal = '0;
    if (isShifted && filled[addr]) oldVal = store[addr];
  end

  always_ff @(posedge clk) begin
    if (strobe.accept && isShifted) store[addr] <= inData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      filled <= '0;
    end else if (strobe.accept && isShifted) begin
      filled[addr] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftData <= '0;
      resData   <= '0;
      outChan   <= '0;
      outPos    <= '0;
    end else if (strobe.accept) begin
      shiftData <= isShifted ? oldVal : inData;
      resData   <= inData;
      outChan   <= inChan;
      outPos    <= inPos;
    end
  end

  AST_UPPER_PASS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.accept && !isShifted |=> shiftData == $past(inData)) else $error("upper channel altered"); // R3
  AST_RES_COPY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.accept |=> resData == $past(inData)) else $error("residual altered"); // R4
  AST_TAG_COPY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.accept |=> outChan == $past(inChan) && outPos == $past(inPos)) else $error("tag altered"); // R8

endmodule

// File: rtl/tshift_unit.sv
module tshift_unit
  import tshift_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CHANNELS = 16,
  parameter int HEIGHT   = 2,
  parameter int WIDTH    = 2,
  localparam int SITES   = HEIGHT * WIDTH,
  localparam int CH_W    = (CHANNELS > 1) ? $clog2(CHANNELS) : 1,
  localparam int POS_W   = (SITES > 1) ? $clog2(SITES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clearBuf,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  input  logic [CH_W-1:0]   inChan,
  input  logic [POS_W-1:0]  inPos,
  output logic              shiftValid,
  input  logic              shiftReady,
  output logic [DATA_W-1:0] shiftData,
  output logic              resValid,
  input  logic              resReady,
  output logic [DATA_W-1:0] resData,
  output logic [CH_W-1:0]   outChan,
  output logic [POS_W-1:0]  outPos
);

  tshift_strobe_t strobe;

  tshift_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .clearBuf   (clearBuf),
    .inValid    (inValid),
    .inReady    (inReady),
    .shiftValid (shiftValid),
    .shiftReady (shiftReady),
    .resValid   (resValid),
    .resReady   (resReady),
    .strobe     (strobe)
  );

  tshift_dp #(
    .DATA_W   (DATA_W),
    .CHANNELS (CHANNELS),
    .SITES    (SITES),
    .CH_W     (CH_W),
    .POS_W    (POS_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .inData    (inData),
    .inChan    (inChan),
    .inPos     (inPos),
    .shiftData (shiftData),
    .resData   (resData),
    .outChan   (outChan),
    .outPos    (outPos)
  );

  AST_SHIFT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    shiftValid && !shiftReady |=> $stable(shiftData) && $stable(outChan) && $stable(outPos))
    else $error("shift data moved under stall"); // R9
  AST_RES_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    resValid && !resReady |=> $stable(resData)) else $error("residual moved under stall"); // R9

endmodule

// File: tb/tshift_unit_tb.sv
`timescale 1ns/1ps
module tshift_unit_tb_top;

  localparam int DATA_W = 8;
  localparam int C      = 16;
  localparam int H      = 2;
  localparam int W      = 2;
  localparam int SH     = C / 8;
  localparam int NW     = C * H * W;

  // Frame table: bit7 clear before frame, bits6:4 stall mode, bits3:0 frame id
  localparam logic [7:0] FRAME_TBL [6] = '{
    8'h01, 8'h12, 8'h23, 8'hB4, 8'h05, 8'h36
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clearBuf = 1'b0;
  logic inValid = 1'b0;
  logic inReady;
  logic [DATA_W-1:0] inData = '0;
  logic [3:0] inChan = '0;
  logic [1:0] inPos = '0;
  logic shiftValid, resValid;
  logic shiftReady = 1'b1;
  logic resReady = 1'b1;
  logic [DATA_W-1:0] shiftData, resData;
  logic [3:0] outChan;
  logic [1:0] outPos;

  int tests = 0;
  int fails = 0;
  int prevId = -1;

  always #2.5 clk = ~clk;

  tshift_unit #(.DATA_W(DATA_W), .CHANNELS(C), .HEIGHT(H), .WIDTH(W)) dut_i (
    .clk(clk), .rstN(rstN), .clearBuf(clearBuf),
    .inValid(inValid), .inReady(inReady), .inData(inData), .inChan(inChan), .inPos(inPos),
    .shiftValid(shiftValid), .shiftReady(shiftReady), .shiftData(shiftData),
    .resValid(resValid), .resReady(resReady), .resData(resData),
    .outChan(outChan), .outPos(outPos)
  );

  function automatic logic [7:0] wordVal(int fr, int pos, int ch);
    return 8'((fr * 37 + pos * 11 + ch * 3 + 1) & 255);
  endfunction

  function automatic logic readyBit(int mode, int cyc, bit isRes);
    case (mode)
      1: return isRes ? 1'b1 : (cyc % 2 == 0);
      2: return isRes ? (cyc % 3 == 0) : 1'b1;
      3: return isRes ? (cyc % 4 != 2) : (cyc % 5 != 1);
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sendFrame(int fid);
    for (int i = 0; i < NW; i++) begin
      @(negedge clk); #1;
      inValid = 1'b1;
      inChan  = 4'(i % C);
      inPos   = 2'(i / C);
      inData  = wordVal(fid, i / C, i % C);
      while (!inReady) begin @(negedge clk); #1; end
      @(posedge clk);
    end
    @(negedge clk); #1;
    inValid = 1'b0;
  endtask

  task automatic recvShift(int fid, int mode);
    int idx = 0;
    int cyc = 0;
    while (idx < NW) begin
      @(negedge clk);
      shiftReady = readyBit(mode, cyc, 1'b0);
      cyc++;
      if (shiftValid && shiftReady) begin
        int ch = idx % C;
        int ps = idx / C;
        int exp;
        if (ch < SH) begin
          exp = (prevId < 0) ? 0 : wordVal(prevId, ps, ch);
          check(shiftData == 8'(exp), (prevId < 0) ? "R5/R6 low channel zero" : "R2/R7 low channel history",
                shiftData, exp);
        end else begin
          exp = wordVal(fid, ps, ch);
          check(shiftData == 8'(exp), "R3 upper channel pass", shiftData, exp);
        end
        check(outChan == 4'(ch) && outPos == 2'(ps), "R8 tag order", {outPos, outChan}, ps * 16 + ch);
        idx++;
      end
    end
    shiftReady = 1'b1;
  endtask

  task automatic recvRes(int fid, int mode);
    int idx = 0;
    int cyc = 0;
    while (idx < NW) begin
      @(negedge clk);
      resReady = readyBit(mode, cyc, 1'b1);
      cyc++;
      if (resValid && resReady) begin
        int exp = wordVal(fid, idx / C, idx % C);
        check(resData == 8'(exp), "R4 residual copy", resData, exp);
        idx++;
      end
    end
    resReady = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    check(!shiftValid && !resValid, "R1 valids low after reset", {shiftValid, resValid}, 0);
    check(inReady == 1'b1, "R1 ready after reset", inReady, 1);

    for (int f = 0; f < 6; f++) begin
      logic [7:0] e;
      int fid, mode;
      e = FRAME_TBL[f];
      fid = int'(e[3:0]);
      mode = int'(e[6:4]);
      if (e[7]) begin
        @(negedge clk); clearBuf = 1'b1; #1;
        check(inReady == 1'b0, "R6 ready low during clear", inReady, 0);
        @(negedge clk); clearBuf = 1'b0;
        prevId = -1;
      end
      fork
        sendFrame(fid);
        recvShift(fid, mode);
        recvRes(fid, mode);
      join
      repeat (3) begin
        @(negedge clk);
        check(!shiftValid && !resValid, "R9 no duplicate word", {shiftValid, resValid}, 0);
      end
      prevId = fid;
    end

    // R10 latency: one word with both consumers ready
    @(negedge clk); #1;
    inValid = 1'b1; inChan = 4'd5; inPos = 2'd1; inData = 8'hA5;
    @(posedge clk);
    @(negedge clk); #1;
    inValid = 1'b0;
    check(shiftValid && resValid, "R10 valid one cycle after accept", {shiftValid, resValid}, 3);
    check(shiftData == 8'hA5, "R10 R3 data after one cycle", shiftData, 8'hA5);
    @(negedge clk);

    // R9 stall: both consumers held off
    shiftReady = 1'b0; resReady = 1'b0;
    #1;
    inValid = 1'b1; inChan = 4'd9; inPos = 2'd2; inData = 8'h3C;
    @(posedge clk);
    @(negedge clk); #1;
    inData = 8'h77; inChan = 4'd10;
    check(inReady == 1'b0, "R9 input stalled", inReady, 0);
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check(shiftValid && shiftData == 8'h3C, "R9 shift held stable", shiftData, 8'h3C);
    check(resValid && resData == 8'h3C, "R9 residual held stable", resData, 8'h3C);
    shiftReady = 1'b1; #1;
    check(inReady == 1'b0, "R9 residual alone still stalls", inReady, 0);
    @(posedge clk);
    @(negedge clk); #1;
    check(!shiftValid && resValid, "R9 shift drained once", {shiftValid, resValid}, 1);
    resReady = 1'b1; #1;
    check(inReady == 1'b1, "R9 ready after drain", inReady, 1);
    @(posedge clk);
    @(negedge clk); #1;
    inValid = 1'b0;
    check(shiftData == 8'h77 && resData == 8'h77, "R9 next word delivered once", shiftData, 8'h77);
    @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule